// File: doc/BRIEF.md
# Reloading Periodic Countdown Timer

This block is a single countdown timer with automatic reload. It advances only on cycles where an external tick-enable is high; the prescaler that produces those ticks lives outside the block. Software sets it up through three 32-bit registers on a simple write-strobe register bus with combinational read data:

- a control word that holds the reload value, the run and interrupt enables, and a sticky expiry flag;
- an acknowledge register;
- a 3-bit route register.

Each time the count runs out, the block raises the sticky flag and at once starts another full period. No software action is needed to keep it periodic.

The interrupt output is a level. Next to it the block drives the two route fields, so that a downstream router can choose the destination core and pick the normal or fast interrupt line. The acknowledge register clears the flag, or restarts the period, without rewriting the configuration.

Registers sit at byte offsets 0x0 (route), 0x4 (control) and 0x8 (acknowledge). Any other offset ignores writes and reads as zero.

Top module: `periodic_timer`

## Requirements
- R1: After reset the control word and the route register both read zero, and `irqOut` is low.
- R2: A control write with bit 28 (run) set and a nonzero reload value N in bits [27:0] starts a fresh period. The flag (bit 31) sets on the Nth cycle after that write in which `tickEn` is high. Cycles with `tickEn` low do not count.
- R3: On expiry the count reloads at once, so the flag sets again after another N ticks with no software action.
- R4: `irqOut` is high exactly while the flag bit 31 and interrupt-enable bit 29 are both set. A control write stores the whole word, including bit 31.
- R5: A control write with bit 28 clear stops the timer, and no expiry occurs however many ticks follow.
- R6: The acknowledge register reads zero. Writing it with bit 31 set clears the flag, and control bits [30:0] stay unchanged.
- R7: Writing the acknowledge register with bit 30 set restarts a full period from the reload value, but only while bit 28 is set. While stopped, such a write leaves the control word unchanged.
- R8: The route register keeps bits [2:0] of a write and reads zero above them. Bits [1:0] drive `routeCore` and bit 2 drives `routeFiq`.
- R9: A reload value of zero never produces an expiry, even with the timer running.
- R10: When an expiry and an acknowledge write that clears the flag fall in the same cycle, the flag ends up set.
- R11: A control write in the same cycle as an expiring tick takes precedence: it starts a fresh period, and the flag takes the written bit 31.
- R12: Writes to unmapped offsets change no register, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Reference tick; the count advances only when high |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Byte offset of the register access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Level interrupt: flag AND interrupt enable |
| routeCore | output | 2 | Destination core selected by the route register |
| routeFiq | output | 1 | High to deliver on the fast interrupt line |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. These are an expiring tick together with a flag-clearing acknowledge, and an expiring tick together with a control rewrite. Each needs the write strobe and the tick to land on exactly the cycle the count runs out.

The bench reaches them by loading a small reload value and counting ticks to one short of expiry. It then drives the final tick and the register write at the same falling edge, so both are captured by the same rising edge. A mid-period restart through the acknowledge register is checked the same way. The bench stops one tick short of expiry, restarts, and shows that a full N further ticks are needed.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 28;

  // control word bit positions (software decodes these)
  localparam int FLAG_BIT   = 31;
  localparam int RESTART_BIT = 30;
  localparam int IEN_BIT    = 29;
  localparam int RUN_BIT    = 28;

  localparam int ROUTE_W = 3;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic             ctrlWr;    // control word rewritten this cycle
    logic             loadNow;   // begin a fresh period
    logic             runEn;     // stored run enable
    logic [CNT_W-1:0] loadVal;   // value loaded on loadNow
    logic [CNT_W-1:0] reloadVal; // stored period length
  } dpCtl_t;
endpackage

// File: rtl/ptmr_count.sv
module ptmr_count
  import ptmr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   tickEn,
  input  dpCtl_t dpCtl,
  output logic   expire
);
  logic [CNT_W-1:0] count;
  logic             advance;

  // a tick is consumed only when running, no rewrite/restart is pending,
  // and the period is nonzero
  always_comb begin
    advance = dpCtl.runEn && !dpCtl.ctrlWr && !dpCtl.loadNow && tickEn &&
              (dpCtl.reloadVal != '0);
    expire  = advance && (count <= CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (dpCtl.loadNow) begin
      count <= dpCtl.loadVal;
    end else if (advance) begin
      if (expire) count <= dpCtl.reloadVal;
      else        count <= count - CNT_W'(1);
    end
  end

  // R2: while running the remaining count never exceeds the period
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.runEn |-> (count <= dpCtl.reloadVal));

  // R5: a stopped timer does not move
  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.runEn && !dpCtl.loadNow) |=> $stable(count));
endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] ROUTE_OFS = 'h0,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h4,
  parameter logic [ADDR_W-1:0] ACK_OFS   = 'h8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  input  logic              expire,
  output logic [WORD_W-1:0] busRdData,
  output dpCtl_t            dpCtl,
  output logic              irqOut,
  output logic [1:0]        routeCore,
  output logic              routeFiq
);
  logic [WORD_W-1:0]  ctrlWord;
  logic [ROUTE_W-1:0] routeReg;
  logic hitCtrl, hitAck, hitRoute;
  logic ackClear, ackRestart;

  always_comb begin
    hitCtrl    = busWrEn && (busAddr == CTRL_OFS);
    hitAck     = busWrEn && (busAddr == ACK_OFS);
    hitRoute   = busWrEn && (busAddr == ROUTE_OFS);
    ackClear   = hitAck && busWrData[FLAG_BIT];
    ackRestart = hitAck && busWrData[RESTART_BIT] && ctrlWord[RUN_BIT];
  end

  always_comb begin
    dpCtl.ctrlWr    = hitCtrl;
    dpCtl.loadNow   = (hitCtrl && busWrData[RUN_BIT]) || ackRestart;
    dpCtl.runEn     = ctrlWord[RUN_BIT];
    dpCtl.loadVal   = hitCtrl ? busWrData[CNT_W-1:0] : ctrlWord[CNT_W-1:0];
    dpCtl.reloadVal = ctrlWord[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
    end else if (hitCtrl) begin
      ctrlWord <= busWrData;
    end else begin
      // clear first, then set: a simultaneous expiry wins
      if (ackClear) ctrlWord[FLAG_BIT] <= 1'b0;
      if (expire)   ctrlWord[FLAG_BIT] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         routeReg <= '0;
    else if (hitRoute) routeReg <= busWrData[ROUTE_W-1:0];
  end

  always_comb begin
    if (busAddr == ROUTE_OFS)     busRdData = {{(WORD_W-ROUTE_W){1'b0}}, routeReg};
    else if (busAddr == CTRL_OFS) busRdData = ctrlWord;
    else                          busRdData = '0;
  end

  assign irqOut    = ctrlWord[FLAG_BIT] && ctrlWord[IEN_BIT];
  assign routeCore = routeReg[1:0];
  assign routeFiq  = routeReg[2];

  // R3: an expiry not overridden by a control write leaves the flag set
  a_r3_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !hitCtrl) |=> ctrlWord[FLAG_BIT]);

  // R6: acknowledge clears the flag when no expiry collides
  a_r6_ack_clears_flag: assert property (@(posedge clk) disable iff (!rstN)
    (ackClear && !expire) |=> !ctrlWord[FLAG_BIT]);

  // R6: acknowledge never touches the configuration bits
  a_r6_ack_keeps_config: assert property (@(posedge clk) disable iff (!rstN)
    hitAck |=> (ctrlWord[FLAG_BIT-1:0] == $past(ctrlWord[FLAG_BIT-1:0])));

  // R8: route changes only on its own write
  a_r8_route_holds: assert property (@(posedge clk) disable iff (!rstN)
    !hitRoute |=> $stable(routeReg));

  // R9: a zero period never raises the flag
  a_r9_zero_never_fires: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlWord[CNT_W-1:0] == '0) && !hitCtrl && !ctrlWord[FLAG_BIT])
      |=> !ctrlWord[FLAG_BIT]);
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
  import ptmr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irqOut,
  output logic [1:0]        routeCore,
  output logic              routeFiq
);
  dpCtl_t dpCtl;
  logic   expire;

  ptmr_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .expire(expire), .busRdData(busRdData),
    .dpCtl(dpCtl), .irqOut(irqOut), .routeCore(routeCore), .routeFiq(routeFiq)
  );

  ptmr_count uCount (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dpCtl(dpCtl), .expire(expire)
  );
endmodule

// File: tb/tb_periodic_timer.sv
module tb_periodic_timer;
  localparam logic [3:0] A_ROUTE = 4'h0;
  localparam logic [3:0] A_CTRL  = 4'h4;
  localparam logic [3:0] A_ACK   = 4'h8;
  localparam logic [3:0] A_HOLE  = 4'hC;
  localparam int NVEC = 4;
  // {reload value, expected tick on which the interrupt appears}
  localparam logic [27:0] VEC [NVEC][2] = '{
    '{28'd1, 28'd1}, '{28'd2, 28'd2}, '{28'd5, 28'd5}, '{28'd13, 28'd13}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic busWrEn = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic irqOut;
  logic [1:0] routeCore;
  logic routeFiq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  periodic_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut), .routeCore(routeCore), .routeFiq(routeFiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  function automatic logic [31:0] cw(input logic [3:0] top, input logic [27:0] n);
    return {top, n};
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
    rd(A_ROUTE, v); chk("R1 route", v, 32'h0);
    chk("R1 irq", {31'b0, irqOut}, 32'h1 & 32'h0);

    // table walk: R2 period, R3 auto restart, R6 ack clear
    for (int k = 0; k < NVEC; k++) begin
      wr(A_CTRL, cw(4'b0011, VEC[k][0]));
      for (int t = 1; t <= int'(VEC[k][1]); t++) begin
        @(negedge clk);           // idle cycle, tickEn low
        tick(1);
        if (t == int'(VEC[k][1]) - 1) chk("R2 early", {31'b0, irqOut}, 32'h0);
      end
      chk("R2 fire", {31'b0, irqOut}, 32'h1);
      wr(A_ACK, 32'h8000_0000);
      chk("R6 cleared", {31'b0, irqOut}, 32'h0);
      tick(int'(VEC[k][0]));
      chk("R3 refire", {31'b0, irqOut}, 32'h1);
      wr(A_ACK, 32'h8000_0000);
    end

    // R6 ack reads zero and keeps config
    rd(A_ACK, v);  chk("R6 ack reads 0", v, 32'h0);
    rd(A_CTRL, v); chk("R6 config kept", v, cw(4'b0011, 28'd13));

    // R4 flag without interrupt enable
    wr(A_CTRL, cw(4'b0001, 28'd3));
    tick(3);
    chk("R4 masked", {31'b0, irqOut}, 32'h0);
    rd(A_CTRL, v); chk("R4 flag set", {31'b0, v[31]}, 32'h1);
    wr(A_CTRL, cw(4'b1010, 28'd3));
    chk("R4 written flag", {31'b0, irqOut}, 32'h1);

    // R5 stop
    wr(A_CTRL, cw(4'b0010, 28'd3));
    tick(10);
    chk("R5 stopped", {31'b0, irqOut}, 32'h0);

    // R7 restart mid-period
    wr(A_CTRL, cw(4'b0011, 28'd4));
    tick(3);
    wr(A_ACK, 32'h4000_0000);
    tick(3);
    chk("R7 restarted", {31'b0, irqOut}, 32'h0);
    tick(1);
    chk("R7 fire", {31'b0, irqOut}, 32'h1);
    wr(A_CTRL, cw(4'b0010, 28'd4));
    wr(A_ACK, 32'h4000_0000);
    rd(A_CTRL, v); chk("R7 stopped no effect", v, cw(4'b0010, 28'd4));

    // R9 zero reload
    wr(A_CTRL, cw(4'b0011, 28'd0));
    tick(20);
    chk("R9 zero", {31'b0, irqOut}, 32'h0);

    // R10 expiry with clearing ack in the same cycle
    wr(A_CTRL, cw(4'b0011, 28'd3));
    tick(2);
    tickEn = 1'b1; busWrEn = 1'b1; busAddr = A_ACK; busWrData = 32'h8000_0000;
    @(negedge clk);
    tickEn = 1'b0; busWrEn = 1'b0; busWrData = '0;
    chk("R10 flag wins", {31'b0, irqOut}, 32'h1);

    // R11 control write wins over expiring tick
    wr(A_CTRL, cw(4'b0011, 28'd2));
    tick(1);
    tickEn = 1'b1; busWrEn = 1'b1; busAddr = A_CTRL; busWrData = cw(4'b0011, 28'd2);
    @(negedge clk);
    tickEn = 1'b0; busWrEn = 1'b0; busWrData = '0;
    chk("R11 no fire", {31'b0, irqOut}, 32'h0);
    tick(1);
    chk("R11 fresh period", {31'b0, irqOut}, 32'h0);
    tick(1);
    chk("R11 fire", {31'b0, irqOut}, 32'h1);

    // R8 route
    wr(A_ROUTE, 32'hFFFF_FFFD);
    chk("R8 core", {30'b0, routeCore}, 32'h1);
    chk("R8 fiq", {31'b0, routeFiq}, 32'h1);
    rd(A_ROUTE, v); chk("R8 read", v, 32'h5);
    wr(A_ROUTE, 32'h2);
    chk("R8 core2", {29'b0, routeFiq, routeCore}, 32'h2);

    // R12 unmapped
    rd(A_CTRL, v);
    wr(A_HOLE, 32'hFFFF_FFFF);
    begin
      logic [31:0] w;
      rd(A_CTRL, w); chk("R12 ctrl kept", w, v);
      rd(A_ROUTE, w); chk("R12 route kept", w, 32'h2);
      rd(A_HOLE, w); chk("R12 hole reads 0", w, 32'h0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule